// File: doc/BRIEF.md
# SIMT Divergence Mask Stack

This block tracks which lanes of a 32-thread lockstep group are allowed to commit results while the group runs through nested conditional code. Every lane executes every instruction. The active mask only decides which lanes write their results back. A sequencer drives three one-cycle strobes: divergence, flip-to-other-path and reconvergence. With the divergence strobe it supplies a per-lane predicate.

On divergence the current mask is saved on an internal LIFO. The new mask is the old mask ANDed with the predicate. On the flip strobe the block takes the saved mask and clears in it the lanes that just ran, so the other path runs on the remaining lanes. On reconvergence the saved mask is restored and removed from the LIFO.

A zero-mask flag lets the sequencer skip a path that no lane will commit. Nesting deeper than the LIFO, or unwinding past its bottom, is reported with an error pulse and changes nothing.

Top module: `simt_mask_stack`

## Requirements
- R1: While `rst` is high and after its release, `mask_o` is all ones, the LIFO holds no entries, and `none_active_o`, `overflow_o` and `underflow_o` are low.
- R2: An accepted `push_i` saves the current mask on top of the LIFO and sets `mask_o` to the old mask AND `pred_i`.
- R3: An accepted `comp_i` sets `mask_o` to the top LIFO entry AND NOT the current mask, and leaves the LIFO untouched.
- R4: An accepted `pop_i` sets `mask_o` to the top LIFO entry and removes that entry.
- R5: `none_active_o` is high in exactly the cycles in which `mask_o` is all zeros.
- R6: A `push_i` while the LIFO holds DEPTH entries raises `overflow_o` for one cycle and leaves the mask and the LIFO unchanged; `overflow_o` is low in every other cycle.
- R7: A `comp_i` or `pop_i` that is selected while the LIFO is empty raises `underflow_o` for one cycle and leaves the mask unchanged; `underflow_o` is low in every other cycle.
- R8: When several strobes are high in one cycle, only one is acted on. `push_i` beats `comp_i`, and `comp_i` beats `pop_i`. The strobes that lose are ignored.
- R9: Every output is registered. A strobe sampled at a rising clock edge shows its effect on the outputs right after that same edge.
- R10: Nested divergences up to DEPTH deep unwind in reverse order, and each pop restores the mask that was current before the matching push.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| push_i | input | 1 | Divergence strobe: save the mask and narrow it by the predicate |
| comp_i | input | 1 | Switch to the lanes of the other path |
| pop_i | input | 1 | Reconvergence strobe: restore the saved mask |
| pred_i | input | LANES | Per-lane branch predicate, used with push_i |
| mask_o | output | LANES | Current active-lane mask |
| none_active_o | output | 1 | High when no lane is active |
| overflow_o | output | 1 | One-cycle pulse: push refused because the LIFO is full |
| underflow_o | output | 1 | One-cycle pulse: flip or pop refused because the LIFO is empty |

## Verification
A wrong LIFO pointer or a corrupted entry stays hidden until a flip or a reconvergence reads the top. At that point it shows up on `mask_o` right after that edge, or as an error pulse at the wrong depth. The bench therefore sweeps every pair of predicates through a full push, flip, pop and pop nest. It also fills the LIFO to its limit and pops it empty, so every entry and both pointer bounds are read back through the ports. A long mixed strobe sequence, compared cycle by cycle with an arithmetic model, catches errors in priority and in flag timing on the first cycle where they differ.

// File: rtl/simt_mask_pkg.sv
package simt_mask_pkg;
  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_PUSH = 2'd1,
    OP_COMP = 2'd2,
    OP_POP  = 2'd3
  } mask_op_e;
endpackage

// File: rtl/simt_op_arbiter.sv
// Picks one strobe by priority and refuses it when the LIFO bound forbids it.
module simt_op_arbiter
  import simt_mask_pkg::*;
(
  input  logic     push_i,
  input  logic     comp_i,
  input  logic     pop_i,
  input  logic     full_i,
  input  logic     empty_i,
  output mask_op_e op_o,
  output logic     ovf_o,
  output logic     unf_o
);
  always_comb begin
    op_o  = OP_NONE;
    ovf_o = 1'b0;
    unf_o = 1'b0;
    if (push_i) begin
      if (full_i) ovf_o = 1'b1;
      else        op_o  = OP_PUSH;
    end else if (comp_i) begin
      if (empty_i) unf_o = 1'b1;
      else         op_o  = OP_COMP;
    end else if (pop_i) begin
      if (empty_i) unf_o = 1'b1;
      else         op_o  = OP_POP;
    end
  end
endmodule

// File: rtl/simt_mask_ram.sv
// Saved-mask storage: one write port, asynchronous read of the top entry.
module simt_mask_ram #(
  parameter int LANES = 32,
  parameter int DEPTH = 8,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             we_i,
  input  logic [AW-1:0]    waddr_i,
  input  logic [LANES-1:0] wdata_i,
  input  logic [AW-1:0]    raddr_i,
  output logic [LANES-1:0] rdata_o
);
  logic [LANES-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we_i) mem[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem[raddr_i];
endmodule

// File: rtl/simt_mask_next.sv
// Per-lane next-mask selection for each accepted operation.
module simt_mask_next
  import simt_mask_pkg::*;
#(
  parameter int LANES = 32
) (
  input  mask_op_e         op_i,
  input  logic [LANES-1:0] cur_i,
  input  logic [LANES-1:0] top_i,
  input  logic [LANES-1:0] pred_i,
  output logic [LANES-1:0] nxt_o,
  output logic             none_o
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign nxt_o[g] = (op_i == OP_PUSH) ? (cur_i[g] & pred_i[g]) :
                      (op_i == OP_COMP) ? (top_i[g] & ~cur_i[g]) :
                      (op_i == OP_POP)  ? top_i[g] :
                                          cur_i[g];
  end

  assign none_o = ~|nxt_o;
endmodule

// File: rtl/simt_mask_stack.sv
module simt_mask_stack
  import simt_mask_pkg::*;
#(
  parameter int LANES = 32,
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push_i,
  input  logic             comp_i,
  input  logic             pop_i,
  input  logic [LANES-1:0] pred_i,
  output logic [LANES-1:0] mask_o,
  output logic             none_active_o,
  output logic             overflow_o,
  output logic             underflow_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  logic [CW-1:0]    sp_q;
  logic [CW-1:0]    top_idx;
  logic [LANES-1:0] mask_q;
  logic [LANES-1:0] top_mask;
  logic [LANES-1:0] nxt_mask;
  logic             nxt_none;
  logic             none_q, ovf_q, unf_q;
  logic             full, empty, ovf, unf;
  mask_op_e         op;

  assign full    = (sp_q == FULL_CNT);
  assign empty   = (sp_q == '0);
  assign top_idx = sp_q - 1'b1;

  simt_op_arbiter u_arb (
    .push_i (push_i),
    .comp_i (comp_i),
    .pop_i  (pop_i),
    .full_i (full),
    .empty_i(empty),
    .op_o   (op),
    .ovf_o  (ovf),
    .unf_o  (unf)
  );

  simt_mask_ram #(.LANES(LANES), .DEPTH(DEPTH)) u_ram (
    .clk    (clk),
    .we_i   (op == OP_PUSH),
    .waddr_i(sp_q[AW-1:0]),
    .wdata_i(mask_q),
    .raddr_i(top_idx[AW-1:0]),
    .rdata_o(top_mask)
  );

  simt_mask_next #(.LANES(LANES)) u_next (
    .op_i  (op),
    .cur_i (mask_q),
    .top_i (top_mask),
    .pred_i(pred_i),
    .nxt_o (nxt_mask),
    .none_o(nxt_none)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '1;
      sp_q   <= '0;
      none_q <= 1'b0;
      ovf_q  <= 1'b0;
      unf_q  <= 1'b0;
    end else begin
      mask_q <= nxt_mask;
      none_q <= nxt_none;
      ovf_q  <= ovf;
      unf_q  <= unf;
      case (op)
        OP_PUSH: sp_q <= sp_q + 1'b1;
        OP_POP:  sp_q <= sp_q - 1'b1;
        default: sp_q <= sp_q;
      endcase
    end
  end

  assign mask_o        = mask_q;
  assign none_active_o = none_q;
  assign overflow_o    = ovf_q;
  assign underflow_o   = unf_q;
endmodule

// File: rtl/simt_mask_stack_chk.sv
module simt_mask_stack_chk #(
  parameter int LANES = 32,
  parameter int DEPTH = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             push_i,
  input logic             comp_i,
  input logic             pop_i,
  input logic [LANES-1:0] pred_i,
  input logic [LANES-1:0] mask_o,
  input logic             none_active_o,
  input logic             overflow_o,
  input logic             underflow_o
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  // Entry count tracked from the strobes alone.
  logic [CW-1:0] cnt;
  logic c_full, c_empty;
  assign c_full  = (cnt == FULL_CNT);
  assign c_empty = (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else if (push_i && !c_full) cnt <= cnt + 1'b1;
    else if (!push_i && !comp_i && pop_i && !c_empty) cnt <= cnt - 1'b1;
  end

  p_reset_mask_r1: assert property (@(posedge clk)
    rst |=> (mask_o == '1 && !overflow_o && !underflow_o && !none_active_o));

  p_push_and_r2: assert property (@(posedge clk) disable iff (rst)
    (push_i && !c_full) |=> (mask_o == ($past(mask_o) & $past(pred_i))));

  p_comp_disjoint_r3: assert property (@(posedge clk) disable iff (rst)
    (!push_i && comp_i && !c_empty) |=> ((mask_o & $past(mask_o)) == '0));

  p_none_flag_r5: assert property (@(posedge clk) disable iff (rst)
    none_active_o == (mask_o == '0));

  p_no_overflow_r6: assert property (@(posedge clk) disable iff (rst)
    (push_i && c_full) |=> (overflow_o && $stable(mask_o)));

  p_no_underflow_r7: assert property (@(posedge clk) disable iff (rst)
    (!push_i && (comp_i || pop_i) && c_empty) |=> (underflow_o && $stable(mask_o)));

  p_err_exclusive_r8: assert property (@(posedge clk) disable iff (rst)
    !(overflow_o && underflow_o));
endmodule

bind simt_mask_stack simt_mask_stack_chk #(.LANES(LANES), .DEPTH(DEPTH)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .push_i       (push_i),
  .comp_i       (comp_i),
  .pop_i        (pop_i),
  .pred_i       (pred_i),
  .mask_o       (mask_o),
  .none_active_o(none_active_o),
  .overflow_o   (overflow_o),
  .underflow_o  (underflow_o)
);

// File: tb/tb_simt_mask_stack.sv
module tb_simt_mask_stack;
  localparam int CLK_PERIOD = 10;
  localparam int L = 4;
  localparam int D = 3;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         push_i = 1'b0, comp_i = 1'b0, pop_i = 1'b0;
  logic [L-1:0] pred_i = '0;
  logic [L-1:0] mask_o;
  logic         none_active_o, overflow_o, underflow_o;

  simt_mask_stack #(.LANES(L), .DEPTH(D)) dut (
    .clk(clk), .rst(rst), .push_i(push_i), .comp_i(comp_i), .pop_i(pop_i),
    .pred_i(pred_i), .mask_o(mask_o), .none_active_o(none_active_o),
    .overflow_o(overflow_o), .underflow_o(underflow_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int errs = 0, checks = 0;
  bit done = 1'b0;

  // Arithmetic model of the mask and LIFO.
  logic [L-1:0] mmask;
  logic [L-1:0] mstk [D];
  int           msp;
  logic         e_ovf, e_unf;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    chk(mask_o == mmask, {tag, " mask"}, int'(mask_o), int'(mmask));
    chk(none_active_o == (mmask == '0), "R5 none flag", int'(none_active_o), int'(mmask == '0));
    chk(overflow_o == e_ovf, "R6 overflow flag", int'(overflow_o), int'(e_ovf));
    chk(underflow_o == e_unf, "R7 underflow flag", int'(underflow_o), int'(e_unf));
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; push_i = 1'b0; comp_i = 1'b0; pop_i = 1'b0;
    @(posedge clk); @(posedge clk); #1;
    mmask = '1; msp = 0; e_ovf = 1'b0; e_unf = 1'b0;
    check_all("R1 reset");
    @(negedge clk);
    rst = 1'b0;
    @(posedge clk); #1;
    check_all("R1 after release");
  endtask

  // Drive one strobe set, update the model, check right after the edge (R9).
  task automatic apply(input logic pu, input logic co, input logic po,
                       input logic [L-1:0] pr, input string tag);
    e_ovf = 1'b0; e_unf = 1'b0;
    if (pu) begin
      if (msp == D) e_ovf = 1'b1;
      else begin mstk[msp] = mmask; msp++; mmask = mmask & pr; end
    end else if (co) begin
      if (msp == 0) e_unf = 1'b1;
      else mmask = mstk[msp-1] & ~mmask;
    end else if (po) begin
      if (msp == 0) e_unf = 1'b1;
      else begin mmask = mstk[msp-1]; msp--; end
    end
    @(negedge clk);
    push_i = pu; comp_i = co; pop_i = po; pred_i = pr;
    @(posedge clk); #1;
    push_i = 1'b0; comp_i = 1'b0; pop_i = 1'b0;
    check_all(tag);
  endtask

  logic [15:0] lfsr;

  initial begin
    mmask = '1; msp = 0; e_ovf = 1'b0; e_unf = 1'b0;
    do_reset();

    // R7: flip and pop on an empty LIFO
    apply(1'b0, 1'b1, 1'b0, '0, "R7 flip on empty");
    apply(1'b0, 1'b0, 1'b1, '0, "R7 pop on empty");
    apply(1'b0, 1'b0, 1'b0, '0, "R7 idle after error");

    // Exhaustive predicate pairs through a two-level nest (R2, R3, R4)
    for (int a = 0; a < (1 << L); a++) begin
      for (int b = 0; b < (1 << L); b++) begin
        apply(1'b1, 1'b0, 1'b0, L'(a), "R2 outer push");
        apply(1'b1, 1'b0, 1'b0, L'(b), "R2 inner push");
        apply(1'b0, 1'b1, 1'b0, '0,    "R3 inner flip");
        apply(1'b0, 1'b0, 1'b1, '0,    "R4 inner pop");
        apply(1'b0, 1'b1, 1'b0, '0,    "R3 outer flip");
        apply(1'b0, 1'b0, 1'b1, '0,    "R4 outer pop");
      end
    end

    // R10 and R6: fill, overflow, unwind in reverse order
    apply(1'b1, 1'b0, 1'b0, 4'b1110, "R10 push 1");
    apply(1'b1, 1'b0, 1'b0, 4'b0111, "R10 push 2");
    apply(1'b1, 1'b0, 1'b0, 4'b1101, "R10 push 3");
    apply(1'b1, 1'b0, 1'b0, 4'b0000, "R6 push when full");
    apply(1'b0, 1'b0, 1'b1, '0, "R10 pop 3");
    apply(1'b0, 1'b0, 1'b1, '0, "R10 pop 2");
    apply(1'b0, 1'b0, 1'b1, '0, "R10 pop 1");
    apply(1'b0, 1'b0, 1'b1, '0, "R7 pop past bottom");

    // R8: simultaneous strobes
    apply(1'b1, 1'b1, 1'b1, 4'b1010, "R8 push wins over flip and pop");
    apply(1'b0, 1'b1, 1'b1, '0,      "R8 flip wins over pop");
    apply(1'b0, 1'b0, 1'b1, '0,      "R8 pop alone");
    apply(1'b0, 1'b1, 1'b1, '0,      "R8 flip wins on empty");

    // R1: reset in the middle of a nest
    apply(1'b1, 1'b0, 1'b0, 4'b0001, "R2 before reset");
    do_reset();
    apply(1'b0, 1'b0, 1'b1, '0, "R1 LIFO emptied by reset");

    // Mixed pseudo-random strobes against the model (R8, R9)
    lfsr = 16'hACE1;
    for (int i = 0; i < 3000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      apply(lfsr[0] & lfsr[1], lfsr[2], lfsr[3], lfsr[7:4], "R8 mixed");
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 190000);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule